// File: doc/BRIEF.md
# SPI Slave Receiver with Select Tagging

This block is an SPI slave whose shift logic runs directly on the external serial clock. It does not oversample with a system clock and it has no clock divider. Bits are captured on the rising SCK edge and launched on the falling edge (mode 0), most significant bit first. The frame length can be set anywhere from 1 to 16 bits.

A configuration input sets the select pin to active low or active high. The pin is converted to an active-low internal select right where it enters the block, so every stage behind that point sees only the active-low form. The slave works only while that internal select is asserted. Releasing the select in the middle of a frame throws the partial word away.

Each completed word crosses into the system clock domain through a toggle handshake and appears as a one-cycle valid pulse. The word carries an active-low select flag. The flag is 0 when the select is still asserted at delivery and 1 when the select was released after the word's final sampling edge, so it marks the word that closed a transfer.

Top module: `spi_tag_slave`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_word` is 0, `rx_sel_n` is 1 and `miso_pin` is 0.
- R2: MOSI is sampled on rising SCK edges, most significant bit first. A completed word is right-aligned in `rx_word`, with its last sampled bit at bit 0.
- R3: A frame is `cfg_len_m1`+1 bits long (1 to 16). Every `rx_word` bit at or above that length reads 0.
- R4: With `cfg_sel_high`=0 the slave is selected while `ssel_pin` is 0. With `cfg_sel_high`=1 it is selected while `ssel_pin` is 1. SCK activity while not selected delivers no word.
- R5: Releasing the select before the last bit of a frame discards the partial frame. No word is delivered, and the next frame after a new select starts from its first bit.
- R6: `rx_sel_n` is 0 when the select stays asserted through delivery of the word. It is 1 when the select was released 1 ns after the word's last rising SCK edge.
- R7: While selected, `miso_pin` presents bit `cfg_len_m1`, then the lower bits in descending order, of `tx_word`. The first bit is valid once the select asserts, and each later bit follows a falling SCK edge. `tx_word` is held stable during a frame.
- R8: `miso_pin` is driven 0 whenever the slave is not selected.
- R9: Each completed word produces exactly one `rx_valid` pulse, one system clock cycle wide, within 40 system cycles.
- R10: Several words sent under one continuous select are each delivered in order, and the bit count restarts at every word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the receive side |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sck_pin | input | 1 | Serial clock from the external master |
| mosi_pin | input | 1 | Serial data from the master |
| ssel_pin | input | 1 | Slave select pin, polarity set by `cfg_sel_high` |
| miso_pin | output | 1 | Serial data to the master, 0 when not selected |
| cfg_sel_high | input | 1 | 1: select pin is active high, 0: active low |
| cfg_len_m1 | input | 4 | Frame length minus one |
| tx_word | input | 16 | Word shifted out on MISO |
| rx_valid | output | 1 | One-cycle pulse when a received word is delivered |
| rx_word | output | 16 | Received word, right-aligned |
| rx_sel_n | output | 1 | Active-low select state captured with the word |

## Verification
The stimulus mixes random data and lengths with both select polarities, so it exercises bit ordering, length masking and the pin inversion together. Directed cases cover the 1-bit and 16-bit lengths, which exercise the counter wrap at its two extremes. An aborted frame followed by a clean one checks that a short frame leaves no residue in the next word. SCK toggling against an inactive pin checks that the polarity setting really gates the slave. Back-to-back words under one select are separated from words that close a transfer, which tells the two flag values apart and shows that the count restarts at each boundary.

// File: rtl/spi_tag_pkg.sv
package spi_tag_pkg;

  typedef enum logic {
    SEL_ACT_LOW  = 1'b0,
    SEL_ACT_HIGH = 1'b1
  } sel_pol_e;

  // Ones in bit positions 0..len_m1, zeros above.
  function automatic logic [31:0] len_mask(input int unsigned len_m1);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i <= int'(len_m1)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Transmit bit index for output slot idx (0 = first bit sent).
  function automatic int unsigned tx_pick(input int unsigned len_m1,
                                          input int unsigned idx);
    return len_m1 - idx;
  endfunction

endpackage

// File: rtl/spi_tag_pin_in.sv
module spi_tag_pin_in
  import spi_tag_pkg::*;
(
  input  logic ssel_pin,
  input  logic cfg_sel_high,
  output logic sel_n
);
  sel_pol_e pol;
  assign pol = sel_pol_e'(cfg_sel_high);

  // Inversion happens only here; everything behind sees active low.
  always_comb begin
    if (pol == SEL_ACT_HIGH) sel_n = ~ssel_pin;
    else                     sel_n = ssel_pin;
  end
endmodule

// File: rtl/spi_tag_shift.sv
module spi_tag_shift
  import spi_tag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              sel_n,
  input  logic [CNT_W-1:0]  cfg_len_m1,
  input  logic [DATA_W-1:0] tx_word,
  output logic              miso,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] hold_word,
  output logic              done_tgl
);
  logic              arst_n;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  oidx_q;
  logic [DATA_W-1:0] part_q;
  logic [DATA_W-1:0] next_part;
  logic [DATA_W-1:0] frame_mask;
  logic [CNT_W-1:0]  tx_idx;
  logic              last_bit;

  // Counter and partial word are cleared whenever select is released.
  assign arst_n     = rst_n & ~sel_n;
  assign last_bit   = (cnt_q == cfg_len_m1);
  assign next_part  = {part_q[DATA_W-2:0], mosi};
  assign frame_mask = DATA_W'(len_mask(32'(cfg_len_m1)));

  always_ff @(posedge sck or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      part_q <= '0;
    end else if (last_bit) begin
      cnt_q  <= '0;
      part_q <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      part_q <= next_part;
    end
  end

  // Holding register survives select release so the handshake can finish.
  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      done_tgl  <= 1'b0;
    end else if (!sel_n && last_bit) begin
      hold_word <= next_part & frame_mask;
      done_tgl  <= ~done_tgl;
    end
  end

  // Output slot follows the counter on the falling edge (mode 0).
  always_ff @(negedge sck or negedge arst_n) begin
    if (!arst_n) oidx_q <= '0;
    else         oidx_q <= cnt_q;
  end

  assign tx_idx  = CNT_W'(tx_pick(32'(cfg_len_m1), 32'(oidx_q)));
  assign miso    = sel_n ? 1'b0 : tx_word[tx_idx];
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/spi_tag_cdc.sv
module spi_tag_cdc #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_tgl,
  input  logic [DATA_W-1:0] hold_word,
  input  logic              sel_n,
  output logic              tgl_edge,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_sel_n
);
  logic [SYNC_STAGES-1:0] tsync;
  logic [SYNC_STAGES-1:0] ssync;
  logic                   tlast;
  logic                   pend;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            tsync[0] <= 1'b0;
            ssync[0] <= 1'b1;
          end else begin
            tsync[0] <= done_tgl;
            ssync[0] <= sel_n;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            tsync[g] <= 1'b0;
            ssync[g] <= 1'b1;
          end else begin
            tsync[g] <= tsync[g-1];
            ssync[g] <= ssync[g-1];
          end
        end
      end
    end
  endgenerate

  assign tgl_edge = tsync[SYNC_STAGES-1] ^ tlast;

  // One extra stage lets the select synchroniser settle past the last edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tlast    <= 1'b0;
      pend     <= 1'b0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
      rx_sel_n <= 1'b1;
    end else begin
      tlast    <= tsync[SYNC_STAGES-1];
      pend     <= tgl_edge;
      rx_valid <= pend;
      if (pend) begin
        rx_word  <= hold_word;
        rx_sel_n <= ssync[SYNC_STAGES-1];
      end
    end
  end
endmodule

// File: rtl/spi_tag_slave.sv
module spi_tag_slave #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_pin,
  input  logic              mosi_pin,
  input  logic              ssel_pin,
  output logic              miso_pin,
  input  logic              cfg_sel_high,
  input  logic [CNT_W-1:0]  cfg_len_m1,
  input  logic [DATA_W-1:0] tx_word,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_sel_n
);
  logic              sel_n_int;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] hold_word;
  logic              done_tgl;
  logic              tgl_edge;

  spi_tag_pin_in pin_i (
    .ssel_pin     (ssel_pin),
    .cfg_sel_high (cfg_sel_high),
    .sel_n        (sel_n_int)
  );

  spi_tag_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) shift_i (
    .rst_n      (rst_n),
    .sck        (sck_pin),
    .mosi       (mosi_pin),
    .sel_n      (sel_n_int),
    .cfg_len_m1 (cfg_len_m1),
    .tx_word    (tx_word),
    .miso       (miso_pin),
    .bit_cnt    (bit_cnt),
    .hold_word  (hold_word),
    .done_tgl   (done_tgl)
  );

  spi_tag_cdc #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) cdc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_tgl  (done_tgl),
    .hold_word (hold_word),
    .sel_n     (sel_n_int),
    .tgl_edge  (tgl_edge),
    .rx_valid  (rx_valid),
    .rx_word   (rx_word),
    .rx_sel_n  (rx_sel_n)
  );
endmodule

// File: rtl/spi_tag_slave_chk.sv
module spi_tag_slave_chk
  import spi_tag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck_pin,
  input logic              sel_n_int,
  input logic              miso_pin,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CNT_W-1:0]  cfg_len_m1,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] upper_bits;
  assign upper_bits = rx_word & ~DATA_W'(len_mask(32'(cfg_len_m1)));

  assert_miso_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_int |-> !miso_pin);

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_word_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (upper_bits == '0));

  assert_cnt_bound_R3: assert property (@(posedge sck_pin) disable iff (!rst_n || sel_n_int)
    bit_cnt <= cfg_len_m1);

  assert_abort_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_int |-> (bit_cnt == '0));
endmodule

bind spi_tag_slave spi_tag_slave_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck_pin    (sck_pin),
  .sel_n_int  (sel_n_int),
  .miso_pin   (miso_pin),
  .bit_cnt    (bit_cnt),
  .cfg_len_m1 (cfg_len_m1),
  .rx_valid   (rx_valid),
  .rx_word    (rx_word)
);

// File: tb/spi_tag_slave_tb.sv
`timescale 1ns/1ps
module spi_tag_slave_tb_top;
  localparam int HALF = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck_pin = 1'b0;
  logic        mosi_pin = 1'b0;
  logic        ssel_pin = 1'b1;
  logic        miso_pin;
  logic        cfg_sel_high = 1'b0;
  logic [3:0]  cfg_len_m1 = 4'd7;
  logic [15:0] tx_word = '0;
  logic        rx_valid;
  logic [15:0] rx_word;
  logic        rx_sel_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  spi_tag_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .mosi_pin(mosi_pin),
    .ssel_pin(ssel_pin), .miso_pin(miso_pin), .cfg_sel_high(cfg_sel_high),
    .cfg_len_m1(cfg_len_m1), .tx_word(tx_word), .rx_valid(rx_valid),
    .rx_word(rx_word), .rx_sel_n(rx_sel_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [15:0] d, input int len_m1);
    logic [15:0] w;
    w = '0;
    for (int i = len_m1; i >= 0; i--) w = {w[14:0], d[i]};
    return w;
  endfunction

  task automatic set_pol(input bit high);
    cfg_sel_high = high;
    ssel_pin     = ~high;
    #(HALF);
  endtask

  task automatic sel_on();
    ssel_pin = cfg_sel_high;
    #(HALF);
  endtask

  task automatic sel_off();
    ssel_pin = ~cfg_sel_high;
    #(HALF);
  endtask

  // Send nsend bits of d; check MISO before each rising edge.
  task automatic xfer(input logic [15:0] d, input int len_m1, input int nsend,
                      input bit rel, output int miso_bad);
    miso_bad = 0;
    for (int i = 0; i < nsend; i++) begin
      mosi_pin = d[len_m1 - i];
      #(HALF);
      if (miso_pin !== tx_word[len_m1 - i]) miso_bad++;
      sck_pin = 1'b1;
      if (rel && i == nsend - 1) begin
        #1 ssel_pin = ~cfg_sel_high;
        #(HALF - 1);
      end else begin
        #(HALF);
      end
      sck_pin = 1'b0;
    end
  endtask

  task automatic get_word(output bit got, output logic [15:0] w, output logic f);
    got = 1'b0; w = '0; f = 1'b0;
    for (int k = 0; k < 40 && !got; k++) begin
      @(negedge clk);
      if (rx_valid) begin
        got = 1'b1; w = rx_word; f = rx_sel_n;
      end
    end
    if (got) begin
      @(negedge clk);
      check(rx_valid == 1'b0, "R9 valid one cycle", 32'(rx_valid), 0);
    end
  endtask

  task automatic full_frame(input logic [15:0] d, input logic [15:0] t,
                            input int len_m1, input bit rel, input string tag);
    bit got; logic [15:0] w; logic f; int bad;
    cfg_len_m1 = 4'(len_m1);
    tx_word    = t;
    sel_on();
    xfer(d, len_m1, len_m1 + 1, rel, bad);
    get_word(got, w, f);
    check(bad == 0, {tag, " R7 miso bits"}, 32'(bad), 0);
    check(got, {tag, " R9 word delivered"}, 32'(got), 1);
    check(w == exp_word(d, len_m1), {tag, " R2 R3 word"}, 32'(w),
          32'(exp_word(d, len_m1)));
    check(f == rel, {tag, " R6 select flag"}, 32'(f), 32'(rel));
    if (!rel) sel_off(); else #(HALF);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit got; logic [15:0] w; logic f; int bad;
    void'($urandom(32'h5eed));
    #30;
    @(negedge clk);
    // R1 reset state
    check(rx_valid == 0, "R1 rx_valid reset", 32'(rx_valid), 0);
    check(rx_word == 0, "R1 rx_word reset", 32'(rx_word), 0);
    check(rx_sel_n == 1, "R1 rx_sel_n reset", 32'(rx_sel_n), 1);
    check(miso_pin == 0, "R1 miso reset", 32'(miso_pin), 0);
    rst_n = 1'b1;
    #(HALF);

    // R2 R3 length extremes
    full_frame(16'hA5C3, 16'h8001, 15, 1'b0, "len16");
    full_frame(16'h0001, 16'h0001, 0, 1'b1, "len1");
    full_frame(16'hFFFE, 16'h0000, 0, 1'b0, "len1zero");

    // R10 back-to-back words under one select, last closes transfer
    cfg_len_m1 = 4'd7; tx_word = 16'h00B4;
    sel_on();
    for (int j = 0; j < 3; j++) begin
      logic [15:0] d;
      d = 16'(8'h3C + 8'(j * 17));
      xfer(d, 7, 8, j == 2, bad);
      get_word(got, w, f);
      check(bad == 0, "R10 R7 miso stream", 32'(bad), 0);
      check(got && w == exp_word(d, 7), "R10 word in sequence", 32'(w),
            32'(exp_word(d, 7)));
      check(f == (j == 2), "R10 R6 flag per word", 32'(f), 32'(j == 2));
    end
    #(HALF);

    // R5 aborted frame then a clean one
    cfg_len_m1 = 4'd11; tx_word = 16'h0ABC;
    sel_on();
    xfer(16'h0FFF, 11, 5, 1'b1, bad);
    get_word(got, w, f);
    check(!got, "R5 aborted frame no word", 32'(got), 0);
    full_frame(16'h0123, 16'h0F0F, 11, 1'b0, "after_abort R5");

    // R4 R8 polarity: active high, pin left inactive
    set_pol(1'b1);
    cfg_len_m1 = 4'd3; tx_word = 16'hFFFF;
    xfer(16'h000F, 3, 4, 1'b0, bad);
    check(bad == 4, "R8 miso low when not selected", 32'(bad), 4);
    get_word(got, w, f);
    check(!got, "R4 no word with inactive pin", 32'(got), 0);
    full_frame(16'h000A, 16'h0005, 3, 1'b1, "R4 active high");
    set_pol(1'b0);
    cfg_len_m1 = 4'd3;
    ssel_pin = 1'b1;
    xfer(16'h000F, 3, 4, 1'b0, bad);
    get_word(got, w, f);
    check(!got, "R4 no word active low idle", 32'(got), 0);

    // Random frames
    for (int r = 0; r < 40; r++) begin
      bit pol; bit rel; int len;
      pol = 1'($urandom % 2);
      rel = 1'($urandom % 2);
      len = int'($urandom % 16);
      if (pol != cfg_sel_high) set_pol(pol);
      full_frame(16'($urandom), 16'($urandom), len, rel, "random");
      check(miso_pin == 0, "R8 miso idle after frame", 32'(miso_pin), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule